// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

A behavioural, synthesizable model of a single-clock static RAM whose word is split into byte lanes. Every input (address, write data, strobes, enables and the order select) is sampled on the rising clock edge. Read data is not registered a second time. The word addressed at an edge appears on the read port shortly after that edge, through combinational logic only.

An access sequence opens with one of two address strobes. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write controls. From then on a 2-bit burst position selects the next three words of the aligned group of four. The position moves only on cycles where the advance input is high. The order select picks either a wrapping increment or an XOR walk of the low two address bits. Each write updates the lanes its controls pick: either the lanes chosen under the byte-write enable, or every lane under the global write.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is low and after it is released, and until the first access is opened, `rd_data` is all zeros.
- R2: An edge with `cs` and `ads_proc` high loads `addr` as the burst start and performs a read. The write controls are ignored on that edge. `rd_data` shows the stored word after that edge.
- R3: `ads_proc` sampled with `cs` low has no effect. A running burst carries on as though the strobe were low, including an advance on that edge.
- R4: An edge with `cs` and `ads_ctl` high loads `addr`, even when `adv` is high. It performs a write if the write controls request one, and a read otherwise.
- R5: `ads_ctl` sampled with `cs` low closes the burst. `rd_data` becomes zero, and later `adv` and write controls have no effect until a new strobe.
- R6: With `order_xor` = 0, burst step n (n = 0..3, counted modulo 4) addresses the start address with its low two bits replaced by (start low bits + n) mod 4. Bits above bit 1 never change within a burst.
- R7: With `order_xor` = 1, burst step n addresses the start address with its low two bits XORed with n.
- R8: On an edge with no accepted strobe and `adv` low, the burst address stays the same.
- R9: With `gbl_wr` = 0 and `byte_wr_en` = 1, bit i of `lane_wr` writes bits 8i+7..8i of the word, and other lanes keep their contents. With `byte_wr_en` = 0, `lane_wr` has no effect.
- R10: `gbl_wr` = 1 writes all four lanes, whatever `byte_wr_en` and `lane_wr` are.
- R11: `rd_data` is zero after an edge that performed a write, and while no burst is open.
- R12: Read data for the address registered at edge N is valid before edge N+1. There is no added pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cs | input | 1 | Chip select, active high |
| ads_proc | input | 1 | Processor address strobe: opens a read burst |
| ads_ctl | input | 1 | Controller address strobe: opens a burst, or closes it when `cs` is low |
| adv | input | 1 | Advance the burst position |
| order_xor | input | 1 | 0: wrapping increment order, 1: XOR order |
| gbl_wr | input | 1 | Write every lane |
| byte_wr_en | input | 1 | Qualifies `lane_wr` |
| lane_wr | input | 4 | Per-lane write select |
| addr | input | 8 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Flow-through read data, zero when idle or writing |

## Verification
An edge can open a new burst while a burst is already in progress and `adv` is high. It can also carry a write request together with a processor strobe. In each case one function must win cleanly: a strobe load must beat the advance, and a forced read must beat the write. The random phase raises both strobes, `adv` and the write controls in the same cycles with fixed-seed draws. Directed steps place a strobe with `cs` low inside a running burst. Each cycle is judged by comparing `rd_data` with a bench model and a reference array, so a wrong winner shows up as a wrong word at once or as corrupted data on a later read.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sb_op_e;

  // Low two address bits for burst step n from the loaded low bits.
  function automatic logic [1:0] burst_low(input logic [1:0] start_lo,
                                           input logic [1:0] n,
                                           input logic       use_xor);
    logic [1:0] r;
    if (use_xor) r = start_lo ^ n;
    else         r = start_lo + n;
    return r;
  endfunction

endpackage

// File: rtl/sburst_lanes.sv
module sburst_lanes #(
  parameter int LANES = 4
) (
  input  logic             gbl_wr,
  input  logic             byte_wr_en,
  input  logic [LANES-1:0] lane_wr,
  output logic             wr_req,
  output logic [LANES-1:0] lane_sel
);

  always_comb begin
    if (gbl_wr)          lane_sel = '1;
    else if (byte_wr_en) lane_sel = lane_wr;
    else                 lane_sel = '0;
    wr_req = |lane_sel;
  end

endmodule

// File: rtl/sburst_seq.sv
module sburst_seq
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs,
  input  logic              ads_proc,
  input  logic              ads_ctl,
  input  logic              adv,
  input  logic              order_xor,
  input  logic              wr_req,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active_q,
  output logic              wr_fire,
  output sb_op_e            op_q
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        pos_q;
  logic [1:0]        pos_nx;
  logic              start;
  logic              proc_start;
  logic              close;
  logic              step;
  logic              open_nx;
  logic [ADDR_W-1:0] step_addr;

  always_comb begin
    start      = cs & (ads_proc | ads_ctl);
    proc_start = cs & ads_proc;
    close      = ads_ctl & ~cs;
    step       = active_q & adv & ~start & ~close;
    pos_nx     = pos_q + 2'd1;
    step_addr  = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], pos_nx, order_xor)};
    if (start)     eff_addr = addr;
    else if (step) eff_addr = step_addr;
    else           eff_addr = cur_addr;
    open_nx = start | (active_q & ~close);
    wr_fire = open_nx & wr_req & ~proc_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      pos_q    <= '0;
      cur_addr <= '0;
      active_q <= 1'b0;
      op_q     <= OP_IDLE;
    end else begin
      cur_addr <= eff_addr;
      active_q <= open_nx;
      if (start) begin
        base_q <= addr;
        pos_q  <= '0;
      end else if (step) begin
        pos_q  <= pos_nx;
      end
      if (!open_nx)     op_q <= OP_IDLE;
      else if (wr_fire) op_q <= OP_WRITE;
      else              op_q <= OP_READ;
    end
  end

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic [LANES-1:0]         we_lanes,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]        raddr,
  input  logic                     rd_en,
  output logic [LANES*LANE_W-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_en ? store[raddr] : '0;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              ads_proc,
  input  logic              ads_ctl,
  input  logic              adv,
  input  logic              order_xor,
  input  logic              gbl_wr,
  input  logic              byte_wr_en,
  input  logic [LANES-1:0]  lane_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic              wr_req;
  logic [LANES-1:0]  lane_sel;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              active_q;
  logic              wr_fire;
  sb_op_e            op_q;
  logic [LANES-1:0]  we_lanes;
  logic              rd_en;

  sburst_lanes #(.LANES(LANES)) u_lanes (
    .gbl_wr    (gbl_wr),
    .byte_wr_en(byte_wr_en),
    .lane_wr   (lane_wr),
    .wr_req    (wr_req),
    .lane_sel  (lane_sel)
  );

  sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .cs       (cs),
    .ads_proc (ads_proc),
    .ads_ctl  (ads_ctl),
    .adv      (adv),
    .order_xor(order_xor),
    .wr_req   (wr_req),
    .eff_addr (eff_addr),
    .cur_addr (cur_addr),
    .active_q (active_q),
    .wr_fire  (wr_fire),
    .op_q     (op_q)
  );

  assign we_lanes = lane_sel & {LANES{wr_fire}};
  assign rd_en    = (op_q == OP_READ);

  sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we_lanes(we_lanes),
    .waddr   (eff_addr),
    .wdata   (wr_data),
    .raddr   (cur_addr),
    .rd_en   (rd_en),
    .rdata   (rd_data)
  );

endmodule

// File: rtl/sburst_sva.sv
module sburst_sva
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              ads_proc,
  input logic              ads_ctl,
  input logic              adv,
  input logic              gbl_wr,
  input logic              byte_wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              active_q,
  input logic              wr_fire,
  input logic [LANES-1:0]  lane_sel,
  input sb_op_e            op_q
);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> rd_data == '0);

  p_write_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> rd_data == '0);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (ads_proc || ads_ctl)) |=> cur_addr == $past(addr));

  p_proc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && ads_proc) |=> op_q == OP_READ);

  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctl && !cs) |=> !active_q);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && (ads_proc || ads_ctl)) && !adv) |=> $stable(cur_addr));

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adv && !ads_ctl && !(cs && ads_proc))
      |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  p_global_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && gbl_wr) |-> lane_sel == '1);

  p_no_byte_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbl_wr && !byte_wr_en) |-> !wr_fire);

endmodule

bind sync_burst_sram sburst_sva #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .ads_proc  (ads_proc),
  .ads_ctl   (ads_ctl),
  .adv       (adv),
  .gbl_wr    (gbl_wr),
  .byte_wr_en(byte_wr_en),
  .addr      (addr),
  .rd_data   (rd_data),
  .cur_addr  (cur_addr),
  .active_q  (active_q),
  .wr_fire   (wr_fire),
  .lane_sel  (lane_sel),
  .op_q      (op_q)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/100ps
module sync_burst_sram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, ads_proc = 0, ads_ctl = 0, adv = 0, order_xor = 0;
  logic        gbl_wr = 0, byte_wr_en = 0;
  logic [3:0]  lane_wr = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  // bench reference state
  logic [31:0] ref_mem [256];
  bit          m_open = 0;
  bit          m_read = 0;
  logic [7:0]  m_base = '0;
  logic [7:0]  m_addr = '0;
  int          m_n = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ads_proc(ads_proc), .ads_ctl(ads_ctl),
    .adv(adv), .order_xor(order_xor), .gbl_wr(gbl_wr), .byte_wr_en(byte_wr_en),
    .lane_wr(lane_wr), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] seq_addr(logic [7:0] b, int n, bit xo);
    if (xo) return b ^ 8'(n);
    return (b & 8'hFC) | (8'(int'(b) + n) & 8'h03);
  endfunction

  function automatic logic [31:0] expect_rd();
    if (m_read) return ref_mem[m_addr];
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, got, exp);
    end
  endtask

  // reference update for one edge, written from the requirement text
  task automatic model_edge();
    bit wants_write;
    wants_write = gbl_wr || (byte_wr_en && lane_wr != 0);
    if (cs && (ads_proc || ads_ctl)) begin
      m_open = 1; m_base = addr; m_n = 0; m_addr = addr;
      if (ads_proc) wants_write = 0;
    end else if (ads_ctl && !cs) begin
      m_open = 0;
    end else if (m_open && adv) begin
      m_n = (m_n + 1) % 4;
      m_addr = seq_addr(m_base, m_n, order_xor);
    end
    if (!m_open) wants_write = 0;
    if (wants_write)
      for (int i = 0; i < 4; i++)
        if (gbl_wr || lane_wr[i]) ref_mem[m_addr][i*8 +: 8] = wr_data[i*8 +: 8];
    m_read = m_open && !wants_write;
  endtask

  task automatic cyc(string tag, bit s, bit sp, bit sc, bit a, bit xo,
                     bit gw, bit bw, logic [3:0] lw, logic [7:0] ad, logic [31:0] wd);
    cs = s; ads_proc = sp; ads_ctl = sc; adv = a; order_xor = xo;
    gbl_wr = gw; byte_wr_en = bw; lane_wr = lw; addr = ad; wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, rd_data, expect_rd());
  endtask

  initial begin : watchdog
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: rd_data=%h expected=run end", rd_data);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] r;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    check("R1 in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rd_data, 32'h0);
    cyc("R1 idle adv", 1, 0, 0, 1, 0, 1, 0, 4'h0, 8'h00, 32'hDEAD_BEEF);

    // fill every word with a global write opened by the controller strobe
    for (int k = 0; k < 256; k++)
      cyc("R4 fill", 1, 0, 1, 0, 0, 1, 0, 4'h0, 8'(k), $urandom);

    // processor strobe forces a read, write request ignored
    cyc("R2 proc read", 1, 1, 0, 0, 0, 1, 1, 4'hF, 8'h10, 32'hFFFF_FFFF);
    cyc("R12 flow read", 1, 0, 0, 0, 0, 0, 0, 4'h0, 8'h99, 32'h0);
    cyc("R8 hold", 1, 0, 0, 0, 0, 0, 0, 4'h0, 8'h55, 32'h0);

    // wrapping increment order from low bits 2
    cyc("R6 start", 1, 0, 1, 0, 0, 0, 0, 4'h0, 8'h22, 32'h0);
    for (int k = 0; k < 4; k++)
      cyc("R6 step", 1, 0, 0, 1, 0, 0, 0, 4'h0, 8'h00, 32'h0);

    // XOR order from low bits 1
    cyc("R7 start", 1, 0, 1, 0, 1, 0, 0, 4'h0, 8'h35, 32'h0);
    for (int k = 0; k < 3; k++)
      cyc("R7 step", 1, 0, 0, 1, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    // strobe while deselected is ignored, advance still applies
    cyc("R3 ignored strobe", 0, 1, 0, 1, 1, 0, 0, 4'h0, 8'hE0, 32'h0);
    cyc("R8 hold xor", 1, 0, 0, 0, 1, 0, 0, 4'h0, 8'hE0, 32'h0);

    // controller strobe beats advance; write then read back
    cyc("R4 write", 1, 0, 1, 1, 0, 1, 0, 4'h0, 8'h40, 32'hA5A5_0F0F);
    cyc("R11 write quiet", 1, 0, 0, 0, 0, 1, 0, 4'h0, 8'h00, 32'h1234_5678);
    cyc("R4 read back", 1, 0, 1, 1, 0, 0, 0, 4'h0, 8'h40, 32'h0);

    // per-lane writes
    cyc("R9 lanes", 1, 0, 1, 0, 0, 0, 1, 4'b0101, 8'h41, 32'h1122_3344);
    cyc("R9 read", 1, 0, 1, 0, 0, 0, 0, 4'h0, 8'h41, 32'h0);
    cyc("R9 no enable", 1, 0, 1, 0, 0, 0, 0, 4'hF, 8'h41, 32'h0000_0000);
    cyc("R9 reread", 1, 0, 0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);

    // global write overrides byte controls
    cyc("R10 global", 1, 0, 1, 0, 0, 1, 1, 4'b0001, 8'h42, 32'hCAFE_F00D);
    cyc("R10 read", 1, 0, 1, 0, 0, 0, 0, 4'h0, 8'h42, 32'h0);

    // close the burst, then advance with writes: nothing happens
    cyc("R5 close", 0, 0, 1, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
    for (int k = 0; k < 3; k++)
      cyc("R5 closed adv", 1, 0, 0, 1, 0, 1, 0, 4'h0, 8'h00, 32'h7777_7777);
    cyc("R5 verify", 1, 0, 1, 0, 0, 0, 0, 4'h0, 8'h43, 32'h0);
    cyc("R5 verify2", 1, 0, 1, 0, 0, 0, 0, 4'h0, 8'h42, 32'h0);

    // random mix of strobes, advance, order and writes
    for (int k = 0; k < 4000; k++) begin
      bit s, sp, sc, a, xo, gw, bw;
      s  = ($urandom % 100) < 85;
      sp = ($urandom % 100) < 12;
      sc = ($urandom % 100) < 15;
      a  = $urandom % 2;
      xo = ($urandom % 100) < 50;
      gw = ($urandom % 100) < 15;
      bw = ($urandom % 100) < 30;
      cyc("R12 random", s, sp, sc, a, xo, gw, bw, 4'($urandom), 8'($urandom), $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule